// File: doc/BRIEF.md
# Fractional Resampling Phase Generator

This block drives the timing side of a rational sample-rate converter. Each output sample of the converter needs two numbers. The first is the fractional phase `r`: how far, in input sample periods, the wanted output instant lies past the current input sample. The second is how many new input samples the filter datapath must shift in before it computes the next output. Both numbers come out of this block, one record for each output sample. A downstream polynomial interpolator consumes the records.

The phase is never recomputed from absolute time. It is carried forward by a recursion. On each output request the generator adds a programmed step, the inverse of the rate-change factor, to the held phase. The step is split into an integer part and an unsigned fractional part. The fractional part wraps the phase back into [0, 1). The wrap carry, added to the integer part of the step, is the advance count for that output.

Interpolation (step below 1) and decimation (step of 1 or more, including factors above 2) differ only in the programmed step values. The structure is the same for both.

Output-rate requests arrive on a valid/ready input, `tick_valid`/`tick_ready`. Records leave on a valid/ready output, `ph_valid`/`ph_ready`, held in a one-deep register.

Back-pressure rules:
- A request is accepted only in a cycle where both `tick_valid` and `tick_ready` are high.
- `tick_ready` is high exactly when the output register is empty, or when its record is being taken in the same cycle.
- A record that has not been taken stays on the output without changing.

Top module: `frac_phase_gen`

## Requirements
- R1: A synchronous reset, active-high `rst`, clears `ph_valid`, `ph_phase` and `ph_adv` to zero, and returns the held phase to zero.
- R2: The first record accepted after reset carries phase 0.
- R3: For consecutive records k and k+1, `ph_phase(k+1) = (ph_phase(k) + step_frac(k)) mod 2^FRAC_W`. `step_frac` is an unsigned fraction with weight 2^-FRAC_W per LSB.
- R4: `ph_adv(k) = step_int(k) + c`. Here c is 1 when `ph_phase(k) + step_frac(k)` reaches 2^FRAC_W, and 0 otherwise.
- R5: A request accepted at a clock edge gives a record with `ph_valid` high right after that edge. Exactly one record is produced for each accepted request.
- R6: While `ph_valid` is high and `ph_ready` is low, `tick_ready` is low, and `ph_phase` and `ph_adv` hold their values.
- R7: A request offered while `tick_ready` is low does not advance the phase. The next record after the stall continues the recursion from the last record that was produced.
- R8: When a record is taken and no new request is accepted in the same cycle, `ph_valid` is low after that edge.
- R9: `step_int` and `step_frac` are sampled only at acceptance. A change of step applies from the record of the request that carries it.
- R10: `ph_adv` is INT_W+1 bits wide and does not wrap. With `step_int` at its maximum and a carry, it reports 2^INT_W (256 for INT_W = 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_valid | input | 1 | Output-rate request offered |
| tick_ready | output | 1 | Request can be accepted this cycle |
| step_int | input | INT_W | Integer part of the inverse rate factor |
| step_frac | input | FRAC_W | Fractional part of the inverse rate factor |
| ph_valid | output | 1 | Phase record present |
| ph_ready | input | 1 | Consumer takes the record |
| ph_phase | output | FRAC_W | Fractional phase r of this output sample |
| ph_adv | output | INT_W+1 | Input samples to advance after this output |

## Verification
A corrupted held phase does not show up straight away. It shows in `ph_phase` of the next record. After that the error never clears, because every later record inherits it through the recursion. The stimulus therefore checks several records in a row, with different steps, rather than isolated samples.

A wrong carry shows in `ph_adv` of the same record. The step table is built so that wraps, exact non-wraps, the all-ones fraction and the largest integer part all occur.

Handshake faults are visible within one cycle. A stalled record that changes, or a request that is wrongly accepted while stalled, shows on the record that follows the stall.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  localparam int unsigned DEF_FRAC_W = 16;
  localparam int unsigned DEF_INT_W  = 8;
endpackage

// File: rtl/fpg_step_add.sv
// Combinational phase recursion: wraps the fraction and forms the advance count.
module fpg_step_add #(
  parameter int unsigned FRAC_W = fpg_pkg::DEF_FRAC_W,
  parameter int unsigned INT_W  = fpg_pkg::DEF_INT_W
) (
  input  logic [FRAC_W-1:0] phase_cur,
  input  logic [INT_W-1:0]  step_int,
  input  logic [FRAC_W-1:0] step_frac,
  output logic [FRAC_W-1:0] phase_nxt,
  output logic [INT_W:0]    adv
);
  localparam int unsigned SUM_W = FRAC_W + 1;
  logic [SUM_W-1:0] sum;
  logic             wrap;

  always_comb begin
    sum       = {1'b0, phase_cur} + {1'b0, step_frac};
    wrap      = sum[FRAC_W];
    phase_nxt = sum[FRAC_W-1:0];
    adv       = {1'b0, step_int} + {{INT_W{1'b0}}, wrap};
  end
endmodule

// File: rtl/fpg_phase_reg.sv
// Held phase register; loads only on accepted requests.
module fpg_phase_reg #(
  parameter int unsigned FRAC_W = fpg_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [FRAC_W-1:0] d,
  output logic [FRAC_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/fpg_out_stage.sv
// One-deep output register with valid/ready handshake.
module fpg_out_stage #(
  parameter int unsigned FRAC_W = fpg_pkg::DEF_FRAC_W,
  parameter int unsigned INT_W  = fpg_pkg::DEF_INT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [FRAC_W-1:0] phase_in,
  input  logic [INT_W:0]    adv_in,
  input  logic              ph_ready,
  output logic              can_load,
  output logic              ph_valid,
  output logic [FRAC_W-1:0] ph_phase,
  output logic [INT_W:0]    ph_adv
);
  assign can_load = !ph_valid || ph_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_valid <= 1'b0;
      ph_phase <= '0;
      ph_adv   <= '0;
    end else if (load) begin
      ph_valid <= 1'b1;
      ph_phase <= phase_in;
      ph_adv   <= adv_in;
    end else if (ph_ready) begin
      ph_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/frac_phase_gen.sv
module frac_phase_gen #(
  parameter int unsigned FRAC_W = fpg_pkg::DEF_FRAC_W,
  parameter int unsigned INT_W  = fpg_pkg::DEF_INT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_valid,
  output logic              tick_ready,
  input  logic [INT_W-1:0]  step_int,
  input  logic [FRAC_W-1:0] step_frac,
  output logic              ph_valid,
  input  logic              ph_ready,
  output logic [FRAC_W-1:0] ph_phase,
  output logic [INT_W:0]    ph_adv
);
  logic              accept;
  logic [FRAC_W-1:0] phase_q;
  logic [FRAC_W-1:0] phase_d;
  logic [INT_W:0]    adv_d;

  assign accept = tick_valid && tick_ready;

  fpg_step_add #(.FRAC_W(FRAC_W), .INT_W(INT_W)) u_add (
    .phase_cur (phase_q),
    .step_int  (step_int),
    .step_frac (step_frac),
    .phase_nxt (phase_d),
    .adv       (adv_d)
  );

  fpg_phase_reg #(.FRAC_W(FRAC_W)) u_phase (
    .clk (clk),
    .rst (rst),
    .en  (accept),
    .d   (phase_d),
    .q   (phase_q)
  );

  fpg_out_stage #(.FRAC_W(FRAC_W), .INT_W(INT_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .phase_in (phase_q),
    .adv_in   (adv_d),
    .ph_ready (ph_ready),
    .can_load (tick_ready),
    .ph_valid (ph_valid),
    .ph_phase (ph_phase),
    .ph_adv   (ph_adv)
  );
endmodule

// File: rtl/frac_phase_gen_chk.sv
module frac_phase_gen_chk #(
  parameter int unsigned FRAC_W = 16,
  parameter int unsigned INT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_valid,
  input logic              tick_ready,
  input logic              ph_valid,
  input logic              ph_ready,
  input logic [FRAC_W-1:0] ph_phase,
  input logic [INT_W:0]    ph_adv
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!ph_valid && ph_phase == '0 && ph_adv == '0));

  a_r5_valid_after_accept: assert property (@(posedge clk) disable iff (rst)
    (tick_valid && tick_ready) |=> ph_valid);

  a_r6_stall_blocks_input: assert property (@(posedge clk) disable iff (rst)
    (ph_valid && !ph_ready) |-> !tick_ready);

  a_r6_stall_holds_record: assert property (@(posedge clk) disable iff (rst)
    (ph_valid && !ph_ready) |=> (ph_valid && $stable(ph_phase) && $stable(ph_adv)));

  a_r8_valid_drops: assert property (@(posedge clk) disable iff (rst)
    (ph_valid && ph_ready && !tick_valid) |=> !ph_valid);
endmodule

bind frac_phase_gen frac_phase_gen_chk #(.FRAC_W(FRAC_W), .INT_W(INT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick_valid (tick_valid),
  .tick_ready (tick_ready),
  .ph_valid   (ph_valid),
  .ph_ready   (ph_ready),
  .ph_phase   (ph_phase),
  .ph_adv     (ph_adv)
);

// File: tb/tb_frac_phase_gen.sv
`timescale 1ns/1ps
module tb_frac_phase_gen;
  localparam int FRAC_W = 16;
  localparam int INT_W  = 8;
  localparam int NV     = 9;

  // step_int, step_frac, expected phase, expected advance (R3, R4, R9, R10)
  localparam logic [7:0]  V_INT  [NV] = '{8'd0, 8'd0, 8'd0, 8'd2, 8'd2, 8'd1, 8'd0, 8'd255, 8'd0};
  localparam logic [15:0] V_FRAC [NV] = '{16'h6000, 16'h6000, 16'h6000, 16'h8000, 16'h8000,
                                          16'hFFFF, 16'h0000, 16'hF000, 16'h1001};
  localparam logic [15:0] V_PH   [NV] = '{16'h0000, 16'h6000, 16'hC000, 16'h2000, 16'hA000,
                                          16'h2000, 16'h1FFF, 16'h1FFF, 16'h0FFF};
  localparam logic [8:0]  V_ADV  [NV] = '{9'd0, 9'd0, 9'd1, 9'd2, 9'd3, 9'd2, 9'd0, 9'd256, 9'd0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_valid = 1'b0;
  logic tick_ready;
  logic [INT_W-1:0]  step_int  = '0;
  logic [FRAC_W-1:0] step_frac = '0;
  logic ph_valid;
  logic ph_ready = 1'b1;
  logic [FRAC_W-1:0] ph_phase;
  logic [INT_W:0]    ph_adv;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  frac_phase_gen #(.FRAC_W(FRAC_W), .INT_W(INT_W)) dut (
    .clk(clk), .rst(rst), .tick_valid(tick_valid), .tick_ready(tick_ready),
    .step_int(step_int), .step_frac(step_frac), .ph_valid(ph_valid),
    .ph_ready(ph_ready), .ph_phase(ph_phase), .ph_adv(ph_adv)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 2000; i++) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    cyc();
    cyc();
    // R1: reset state
    check("R1 valid", {31'd0, ph_valid}, 32'd0);
    check("R1 phase", {16'd0, ph_phase}, 32'd0);
    check("R1 adv", {23'd0, ph_adv}, 32'd0);
    rst = 1'b0;

    // table walk, one request per cycle, consumer always ready
    for (int i = 0; i < NV; i++) begin
      tick_valid = 1'b1;
      step_int   = V_INT[i];
      step_frac  = V_FRAC[i];
      cyc();
      check($sformatf("R5 valid v%0d", i), {31'd0, ph_valid}, 32'd1);
      check($sformatf("R3 phase v%0d", i), {16'd0, ph_phase}, {16'd0, V_PH[i]});
      check($sformatf("R4 R10 adv v%0d", i), {23'd0, ph_adv}, {23'd0, V_ADV[i]});
    end
    // held phase is now 0x2000

    // R6 / R7: stall with a pending request carrying a new step
    ph_ready  = 1'b0;
    step_int  = 8'd0;
    step_frac = 16'h4000;
    cyc();
    // last table record must still be held
    check("R6 tick_ready low", {31'd0, tick_ready}, 32'd0);
    for (int k = 0; k < 3; k++) begin
      cyc();
      check("R6 phase held", {16'd0, ph_phase}, 32'h0FFF);
      check("R6 adv held", {23'd0, ph_adv}, 32'd0);
    end
    ph_ready = 1'b1;
    cyc();
    check("R7 phase after stall", {16'd0, ph_phase}, 32'h2000);
    check("R9 adv after stall", {23'd0, ph_adv}, 32'd0);
    tick_valid = 1'b0;
    cyc();
    check("R8 valid drops", {31'd0, ph_valid}, 32'd0);
    cyc();
    check("R8 stays idle", {31'd0, ph_valid}, 32'd0);
    // the next request continues the recursion from 0x6000
    tick_valid = 1'b1;
    step_int   = 8'd1;
    step_frac  = 16'hA000;
    cyc();
    tick_valid = 1'b0;
    check("R3 phase after idle", {16'd0, ph_phase}, 32'h6000);
    check("R4 adv carry", {23'd0, ph_adv}, 32'd2);

    // R1/R2: reset in mid-stream, then the first record has phase 0
    rst = 1'b1;
    cyc();
    rst = 1'b0;
    check("R1 valid mid reset", {31'd0, ph_valid}, 32'd0);
    tick_valid = 1'b1;
    step_int   = 8'd0;
    step_frac  = 16'h8000;
    cyc();
    tick_valid = 1'b0;
    check("R2 first phase", {16'd0, ph_phase}, 32'd0);
    check("R2 first adv", {23'd0, ph_adv}, 32'd0);
    cyc();
    finish_run();
  end
endmodule